// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one capture/compare channel that sits beside a shared free-running timer count. It can either record the count value at which a chosen input changes (capture), or watch for the count reaching a programmed value (compare) and drive an output pin from that event. When several channels are built, the equality event of the first one is fed to the others. Some output modes use it to return their pin to a known level once per period, which gives edge-aligned or centred pulse-width modulation.

Software reaches the channel through a two-register port. One register holds the 16-bit capture/compare value. The other holds the configuration and status bits. A flag marks each capture or compare event and can raise an interrupt. An overflow bit marks a capture that was lost because the previous one was not yet serviced. A sampled-input bit keeps the level of the selected input as it was at the last compare event. The `tmr_tick` input marks the cycles on which the timer clock advances, and compare events happen only on those cycles.

Top module: `cc_channel`

## Requirements
- R1: After reset, the control register reads 0, the value register reads 0, `out_pin` is 0 and `irq` is 0.
- R2: Control bit 0 selects compare (0) or capture (1) and may be changed at any time. In compare mode, when `tmr_tick` is 1 and `tmr_count` equals the value register, the flag (control bit 11) reads 1 after that clock edge. This does not happen when `tmr_tick` is 0, and it never happens in capture mode.
- R3: In capture mode, control bits [2:1] choose the trigger: 0 none, 1 rising edge, 2 falling edge, 3 either edge. On the chosen edge, `tmr_count` is copied into the value register and the flag is set.
- R4: Control bits [4:3] select the capture source: 0 `in_a`, 1 `in_b`, 2 constant 0, 3 constant 1. Inputs that are not selected cause no capture.
- R5: When control bit 5 is 1, the selected input passes through a two-stage synchronizer before edge detection. A change in the input is then captured at the third clock edge after it, instead of the first.
- R6: A capture that occurs while the flag is already 1 sets the overflow bit (control bit 12). Writing 0 to the flag or overflow bit clears it. A hardware set wins over a software write in the same cycle.
- R7: On each compare event, the level of the selected input is stored in control bit 13, which is read-only.
- R8: Control bits [8:6] choose the output mode. Mode 0 copies control bit 9 to `out_pin`. Mode 1 sets the pin on the channel's own match, mode 4 toggles it, and mode 5 clears it. Without an event, the pin holds.
- R9: Modes 2 and 3 clear the pin on `eq0_in`; on an own match alone, mode 2 toggles and mode 3 sets. Modes 6 and 7 set the pin on `eq0_in`; on an own match alone, mode 6 toggles and mode 7 clears. When both events occur together, the `eq0_in` action wins.
- R10: When parameter IS_CH0 is 1, `eq0_in` is ignored and modes 2, 3, 6, 7 behave as modes 4, 1, 4, 5.
- R11: `irq` is 1 exactly while both the flag and the interrupt enable (control bit 10) are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tmr_tick | input | 1 | Timer clock advances this cycle |
| tmr_count | input | W | Shared timer count |
| eq0_in | input | 1 | Channel-0 equality event |
| in_a | input | 1 | Capture input A |
| in_b | input | 1 | Capture input B |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 value |
| wr_data | input | W | Write data |
| rd_sel | input | 1 | Read target: 0 control, 1 value |
| rd_data | output | W | Read data |
| own_eq | output | 1 | This channel's equality event |
| irq | output | 1 | Interrupt request |
| out_pin | output | 1 | Output unit pin |

## Verification
The hardest situation to reach is a clash at the output flip-flop: an own match and a channel-0 event in the same timer tick, arriving with the pin already at either level, in all eight modes. The bench first forces the starting level through mode 0. It then switches to the target mode and applies one tick with every pairing of the two events. It does this on a normal channel and on a channel-0 instance side by side. The bench also checks the synchronizer latency, by stepping the count on every cycle so that the captured value shows which edge caught the change.

// File: rtl/cc_pkg.sv
package cc_pkg;
   typedef enum logic [2:0] {
      OM_SW      = 3'd0,
      OM_SET     = 3'd1,
      OM_TOG_RST = 3'd2,
      OM_SET_RST = 3'd3,
      OM_TOG     = 3'd4,
      OM_RST     = 3'd5,
      OM_TOG_SET = 3'd6,
      OM_RST_SET = 3'd7
   } out_mode_e;

   localparam int CB_CAP   = 0;
   localparam int CB_EDGE  = 1;
   localparam int CB_INSEL = 3;
   localparam int CB_SYNC  = 5;
   localparam int CB_MODE  = 6;
   localparam int CB_SWOUT = 9;
   localparam int CB_IEN   = 10;
   localparam int CB_FLAG  = 11;
   localparam int CB_OVF   = 12;
   localparam int CB_SAMP  = 13;
   localparam int CTL_W    = 16;
endpackage

// File: rtl/cc_capture.sv
module cc_capture #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_a,
   input  logic       in_b,
   input  logic [1:0] insel,
   input  logic       sync_en,
   input  logic [1:0] edge_sel,
   output logic       sel_raw,
   output logic       cap_hit
);
   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_stage_chk
      $error("cc_capture: SYNC_STAGES must be at least 2");
   end

   logic [LAST:0] sh_q;
   logic          sig, prev_q, rise, fall;

   always_comb begin
      case (insel)
         2'd0:    sel_raw = in_a;
         2'd1:    sel_raw = in_b;
         2'd2:    sel_raw = 1'b0;
         default: sel_raw = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[LAST-1:0], sel_raw};
         prev_q <= sig;
      end
   end

   assign sig  = sync_en ? sh_q[LAST] : sel_raw;
   assign rise = sig & ~prev_q;
   assign fall = ~sig & prev_q;

   always_comb begin
      case (edge_sel)
         2'd1:    cap_hit = rise;
         2'd2:    cap_hit = fall;
         2'd3:    cap_hit = rise | fall;
         default: cap_hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/cc_outunit.sv
module cc_outunit
   import cc_pkg::*;
#(
   parameter bit IS_CH0 = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] mode,
   input  logic       sw_bit,
   input  logic       own_eq,
   input  logic       eq0,
   output logic       out_q
);
   out_mode_e eff_mode;
   logic      eq0_eff;
   logic      out_d;

   if (IS_CH0) begin : g_ch0
      always_comb begin
         case (out_mode_e'(mode))
            OM_TOG_RST: eff_mode = OM_TOG;
            OM_SET_RST: eff_mode = OM_SET;
            OM_TOG_SET: eff_mode = OM_TOG;
            OM_RST_SET: eff_mode = OM_RST;
            default:    eff_mode = out_mode_e'(mode);
         endcase
      end
      assign eq0_eff = 1'b0;
   end else begin : g_chn
      assign eff_mode = out_mode_e'(mode);
      assign eq0_eff  = eq0;
   end

   always_comb begin
      out_d = out_q;
      case (eff_mode)
         OM_SW:      out_d = sw_bit;
         OM_SET:     if (own_eq) out_d = 1'b1;
         OM_TOG_RST: if (eq0_eff) out_d = 1'b0; else if (own_eq) out_d = ~out_q;
         OM_SET_RST: if (eq0_eff) out_d = 1'b0; else if (own_eq) out_d = 1'b1;
         OM_TOG:     if (own_eq) out_d = ~out_q;
         OM_RST:     if (own_eq) out_d = 1'b0;
         OM_TOG_SET: if (eq0_eff) out_d = 1'b1; else if (own_eq) out_d = ~out_q;
         OM_RST_SET: if (eq0_eff) out_d = 1'b1; else if (own_eq) out_d = 1'b0;
         default:    out_d = out_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= 1'b0;
      else        out_q <= out_d;
   end
endmodule

// File: rtl/cc_channel.sv
module cc_channel
   import cc_pkg::*;
#(
   parameter int W           = 16,
   parameter bit IS_CH0      = 1'b0,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tmr_tick,
   input  logic [W-1:0] tmr_count,
   input  logic         eq0_in,
   input  logic         in_a,
   input  logic         in_b,
   input  logic         wr_en,
   input  logic         wr_sel,
   input  logic [W-1:0] wr_data,
   input  logic         rd_sel,
   output logic [W-1:0] rd_data,
   output logic         own_eq,
   output logic         irq,
   output logic         out_pin
);
   if (W < CTL_W) begin : g_w_chk
      $error("cc_channel: W must be at least 16");
   end

   logic         cap_mode, sync_en, sw_out, ien, flag_q, ovf_q, samp_q;
   logic [1:0]   edge_sel, insel;
   logic [2:0]   out_mode;
   logic [W-1:0] ccr_q;
   logic         sel_raw, cap_hit, cap_evt, set_evt, ctl_wr;
   logic [CTL_W-1:0] ctl_view;

   cc_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
      .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b),
      .insel(insel), .sync_en(sync_en), .edge_sel(edge_sel),
      .sel_raw(sel_raw), .cap_hit(cap_hit)
   );

   assign cap_evt = cap_mode & cap_hit;
   assign own_eq  = ~cap_mode & tmr_tick & (tmr_count == ccr_q);
   assign set_evt = cap_evt | own_eq;
   assign ctl_wr  = wr_en & ~wr_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_mode <= 1'b0;
         edge_sel <= '0;
         insel    <= '0;
         sync_en  <= 1'b0;
         out_mode <= '0;
         sw_out   <= 1'b0;
         ien      <= 1'b0;
         flag_q   <= 1'b0;
         ovf_q    <= 1'b0;
         samp_q   <= 1'b0;
         ccr_q    <= '0;
      end else begin
         if (ctl_wr) begin
            cap_mode <= wr_data[CB_CAP];
            edge_sel <= wr_data[CB_EDGE +: 2];
            insel    <= wr_data[CB_INSEL +: 2];
            sync_en  <= wr_data[CB_SYNC];
            out_mode <= wr_data[CB_MODE +: 3];
            sw_out   <= wr_data[CB_SWOUT];
            ien      <= wr_data[CB_IEN];
         end
         if (set_evt)     flag_q <= 1'b1;
         else if (ctl_wr) flag_q <= wr_data[CB_FLAG];
         if (cap_evt && flag_q) ovf_q <= 1'b1;
         else if (ctl_wr)       ovf_q <= wr_data[CB_OVF];
         if (own_eq) samp_q <= sel_raw;
         if (cap_evt)                ccr_q <= tmr_count;
         else if (wr_en && wr_sel)   ccr_q <= wr_data;
      end
   end

   cc_outunit #(.IS_CH0(IS_CH0)) u_out (
      .clk(clk), .rst_n(rst_n), .mode(out_mode), .sw_bit(sw_out),
      .own_eq(own_eq), .eq0(eq0_in), .out_q(out_pin)
   );

   always_comb begin
      ctl_view                  = '0;
      ctl_view[CB_CAP]          = cap_mode;
      ctl_view[CB_EDGE +: 2]    = edge_sel;
      ctl_view[CB_INSEL +: 2]   = insel;
      ctl_view[CB_SYNC]         = sync_en;
      ctl_view[CB_MODE +: 3]    = out_mode;
      ctl_view[CB_SWOUT]        = sw_out;
      ctl_view[CB_IEN]          = ien;
      ctl_view[CB_FLAG]         = flag_q;
      ctl_view[CB_OVF]          = ovf_q;
      ctl_view[CB_SAMP]         = samp_q;
   end

   assign rd_data = rd_sel ? ccr_q : W'(ctl_view);
   assign irq     = flag_q & ien;
endmodule

// File: rtl/cc_channel_chk.sv
module cc_channel_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cap_evt,
   input logic         flag,
   input logic         ovf,
   input logic [W-1:0] ccr,
   input logic [W-1:0] count,
   input logic [2:0]   mode,
   input logic         own_eq,
   input logic         eq0,
   input logic         out_q
);
   p_cmp_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      own_eq |=> flag);
   p_cap_val_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> (ccr == $past(count)));
   p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_evt && flag) |=> ovf);
   p_out_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd1 && own_eq) |=> out_q);
   p_out_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd5 && own_eq) |=> !out_q);
   p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 3'd0 && !own_eq && !eq0) |=> $stable(out_q));
endmodule

bind cc_channel cc_channel_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .flag(flag_q), .ovf(ovf_q),
   .ccr(ccr_q), .count(tmr_count), .mode(out_mode), .own_eq(own_eq),
   .eq0(eq0_in), .out_q(out_pin)
);

// File: tb/cc_channel_test.sv
module cc_channel_test;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic tmr_tick = 1'b0, eq0_in = 1'b0, in_a = 1'b0, in_b = 1'b0;
   logic wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
   logic [W-1:0] tmr_count = 16'd5, wr_data = '0;
   logic [W-1:0] rd_data, rd_data0;
   logic own_eq, irq, out_pin, own_eq0, irq0, out0;
   int total = 0, bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cc_channel #(.W(W), .IS_CH0(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick), .tmr_count(tmr_count),
      .eq0_in(eq0_in), .in_a(in_a), .in_b(in_b), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .own_eq(own_eq),
      .irq(irq), .out_pin(out_pin));

   cc_channel #(.W(W), .IS_CH0(1'b1)) uut0 (
      .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick), .tmr_count(tmr_count),
      .eq0_in(eq0_in), .in_a(in_a), .in_b(in_b), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data0), .own_eq(own_eq0),
      .irq(irq0), .out_pin(out0));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] mkctl(input logic cap, input logic [1:0] es,
         input logic [1:0] isel, input logic sy, input logic [2:0] m,
         input logic sw, input logic ie, input logic fl, input logic ov);
      logic [15:0] v = '0;
      v[0] = cap; v[2:1] = es; v[4:3] = isel; v[5] = sy; v[8:6] = m;
      v[9] = sw; v[10] = ie; v[11] = fl; v[12] = ov;
      return v;
   endfunction

   task automatic wr(input logic sel, input logic [15:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic sel, output logic [15:0] v);
      rd_sel = sel; #1; v = rd_data;
   endtask

   function automatic logic exp_out(input int m, input logic init, input logic e,
         input logic z, input bit ch0);
      int mm = m;
      logic zz = z;
      if (ch0) begin
         zz = 1'b0;
         case (m)
            2: mm = 4; 3: mm = 1; 6: mm = 4; 7: mm = 5;
            default: mm = m;
         endcase
      end
      case (mm)
         1: return e ? 1'b1 : init;
         2: return zz ? 1'b0 : (e ? ~init : init);
         3: return zz ? 1'b0 : (e ? 1'b1 : init);
         4: return e ? ~init : init;
         5: return e ? 1'b0 : init;
         6: return zz ? 1'b1 : (e ? ~init : init);
         7: return zz ? 1'b1 : (e ? 1'b0 : init);
         default: return init;
      endcase
   endfunction

   task automatic setup_cap(input logic [1:0] isel, input logic sy);
      wr(0, mkctl(0, 0, isel, sy, 0, 0, 0, 0, 0));
      repeat (3) @(negedge clk);
      wr(1, 16'hDEAD);
      wr(0, mkctl(1, 2'd3, isel, sy, 0, 0, 0, 0, 0));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(0, v); chk("R1 ctrl", v, 0);
      rd(1, v); chk("R1 ccr", v, 0);
      chk("R1 out", out_pin, 0);
      chk("R1 irq", irq, 0);

      // R2 compare flag only on tick, never in capture mode
      wr(1, 16'd100);
      tmr_count = 16'd100;
      @(negedge clk);
      rd(0, v); chk("R2 no tick no flag", v[11], 0);
      wr(0, mkctl(1, 0, 0, 0, 0, 0, 0, 0, 0));
      tmr_tick = 1'b1; @(negedge clk); tmr_tick = 1'b0;
      rd(0, v); chk("R2 capture mode no flag", v[11], 0);
      // R7 sample + R11 irq
      in_a = 1'b1;
      wr(0, mkctl(0, 0, 0, 0, 0, 0, 1, 0, 0));
      chk("R11 irq low before event", irq, 0);
      tmr_tick = 1'b1; @(negedge clk); tmr_tick = 1'b0;
      rd(0, v); chk("R2 flag on match", v[11], 1);
      chk("R7 sample high", v[13], 1);
      chk("R11 irq with enable", irq, 1);
      in_a = 1'b0;
      tmr_tick = 1'b1; @(negedge clk); tmr_tick = 1'b0;
      rd(0, v); chk("R7 sample low", v[13], 0);
      wr(0, mkctl(0, 0, 0, 0, 0, 0, 1, 0, 0));
      chk("R11 irq after flag clear", irq, 0);
      wr(0, mkctl(0, 0, 0, 0, 0, 0, 0, 1, 0));
      chk("R11 irq masked", irq, 0);
      tmr_count = 16'd5;

      // R3 edge selection sweep
      for (int es = 0; es < 4; es++) begin
         for (int dir = 0; dir < 2; dir++) begin
            logic hit;
            logic [15:0] cv;
            in_a = (dir == 1);
            wr(0, mkctl(0, 0, 0, 0, 0, 0, 0, 0, 0));
            wr(1, 16'hDEAD);
            wr(0, mkctl(1, es[1:0], 0, 0, 0, 0, 0, 0, 0));
            cv = 16'(1000 + es * 2 + dir);
            tmr_count = cv;
            in_a = ~in_a;
            @(negedge clk);
            hit = (es == 3) || (es == 1 && dir == 0) || (es == 2 && dir == 1);
            rd(1, v); chk("R3 capture value", v, hit ? cv : 16'hDEAD);
            rd(0, v); chk("R3 capture flag", v[11], hit);
         end
      end

      // R4 input select
      in_a = 1'b0; in_b = 1'b0;
      setup_cap(2'd1, 0);
      tmr_count = 16'd300; in_a = 1'b1; @(negedge clk);
      rd(1, v); chk("R4 unselected in_a ignored", v, 16'hDEAD);
      tmr_count = 16'd301; in_b = 1'b1; @(negedge clk);
      rd(1, v); chk("R4 in_b captured", v, 16'd301);
      setup_cap(2'd2, 0);
      in_a = 1'b0; in_b = 1'b0; @(negedge clk);
      rd(1, v); chk("R4 ground no capture", v, 16'hDEAD);
      setup_cap(2'd3, 0);
      in_a = 1'b1; in_b = 1'b1; @(negedge clk);
      rd(1, v); chk("R4 vcc no capture", v, 16'hDEAD);
      setup_cap(2'd0, 0);
      in_b = 1'b0; @(negedge clk);
      rd(1, v); chk("R4 unselected in_b ignored", v, 16'hDEAD);

      // R5 synchronizer latency
      setup_cap(2'd0, 1);
      tmr_count = 16'd200; in_a = 1'b0; @(negedge clk);
      rd(1, v); chk("R5 not yet captured", v, 16'hDEAD);
      tmr_count = 16'd201; @(negedge clk);
      tmr_count = 16'd202; @(negedge clk);
      rd(1, v); chk("R5 sync capture on third edge", v, 16'd202);
      setup_cap(2'd0, 0);
      tmr_count = 16'd200; in_a = 1'b1; @(negedge clk);
      tmr_count = 16'd201;
      rd(1, v); chk("R5 direct capture on first edge", v, 16'd200);

      // R6 overflow
      setup_cap(2'd0, 0);
      tmr_count = 16'd400; in_a = 1'b0; @(negedge clk);
      rd(0, v); chk("R6 first capture flag", v[11], 1);
      chk("R6 no overflow yet", v[12], 0);
      tmr_count = 16'd401; in_a = 1'b1; @(negedge clk);
      rd(0, v); chk("R6 overflow set", v[12], 1);
      rd(1, v); chk("R6 newest value kept", v, 16'd401);
      wr(0, mkctl(1, 2'd3, 0, 0, 0, 0, 0, 0, 0));
      rd(0, v); chk("R6 flag cleared", v[11], 0);
      chk("R6 overflow cleared", v[12], 0);
      tmr_count = 16'd5;

      // R8 R9 R10 output mode sweep on both channel flavours
      wr(0, mkctl(0, 0, 0, 0, 0, 0, 0, 0, 0));
      wr(1, 16'd100);
      for (int m = 0; m < 8; m++) begin
         for (int init = 0; init < 2; init++) begin
            for (int ez = 0; ez < 4; ez++) begin
               logic e, z;
               e = ez[0]; z = ez[1];
               wr(0, mkctl(0, 0, 0, 0, 0, init[0], 0, 0, 0));
               wr(0, mkctl(0, 0, 0, 0, m[2:0], init[0], 0, 0, 0));
               tmr_tick = 1'b1; eq0_in = z;
               tmr_count = e ? 16'd100 : 16'd5;
               @(negedge clk);
               tmr_tick = 1'b0; eq0_in = 1'b0; tmr_count = 16'd5;
               if (m == 0 || m == 1 || m == 4 || m == 5)
                  chk("R8 output mode", out_pin, exp_out(m, init[0], e, z, 0));
               else
                  chk("R9 output mode with eq0", out_pin, exp_out(m, init[0], e, z, 0));
               chk("R10 channel-0 remap", out0, exp_out(m, init[0], e, z, 1));
            end
         end
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule